// File: doc/BRIEF.md
# Converter Serial Port Sleep Logic

This block is the device-side digital logic behind a delta-sigma converter's two-wire serial output. One pin carries both the data-ready flag and the serial data. The host supplies a serial clock and nothing else. The block takes each finished 24-bit result from the modulator interface and pulls the shared pin low to say a result is waiting. It then shifts the result out, most significant bit first, on rising edges of the serial clock.

The host can use the serial clock alone to put the converter to sleep. Once a result has been announced, a serial clock held high for a set number of master-clock cycles puts the block into sleep. This may happen partway through a readback. While asleep, the pin stays high and new results are discarded. Taking the clock low wakes the block. After a settling delay, the block captures the result on the modulator interface and announces it, and that first result is valid. If 25 complete clock pulses were shifted before the clock was parked high, wakeup runs a self-calibration first, modelled as a longer fixed delay.

The serial clock is resynchronised into the master-clock domain. All durations are parameters counted in master-clock cycles. Used this way, the host can run single conversions: wake the block, read one result, then park the clock high again.

Top module: `sdx_serial_port`

## Requirements
- R1: While reset is held and after it is released, with no result presented, the data pin `sdo_o` is 1, `sleep_o` is 0 and `cal_busy_o` is 0.
- R2: A one-cycle `conv_done_i` pulse while awake loads `conv_data_i` and drives `sdo_o` to 0 after the next master-clock edge. This also clears any armed calibration.
- R3: The k-th serial clock rise after a load (k = 1..24) drives bit 24-k of the result onto `sdo_o`, most significant bit first. The new value appears on the third master-clock edge after `sclk_i` rises.
- R4: The 25th rise drives `sdo_o` to 1. Later rises leave `sdo_o` at 1 until the next result.
- R5: After a result has been announced, `sclk_i` held high sets `sleep_o` on master edge SLEEP_CYC+2 after it rises, and `sdo_o` is 1 while asleep. A high phase shorter than that is an ordinary shift phase and does not cause sleep.
- R6: Before any result has been announced, a long high `sclk_i` does not cause sleep.
- R7: While asleep, `conv_done_i` pulses are ignored and `sdo_o` stays 1.
- R8: When `sclk_i` falls during sleep, `sleep_o` clears on the third master edge. `sdo_o` goes to 0 on edge D+3, where D is WAKE_CYC without calibration, and the result loaded is the value of `conv_data_i` at that edge.
- R9: If 25 complete serial clock pulses (rise and fall) were shifted before sleep, D is CAL_CYC instead, and `cal_busy_o` is 1 from the third edge until the result appears.
- R10: An armed calibration is dropped when a new result is loaded without sleep. It is also dropped when the calibration delay completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, asynchronous to `clk` |
| conv_done_i | input | 1 | One-cycle strobe from the modulator: a result is finished |
| conv_data_i | input | DATA_W | Result from the modulator |
| sdo_o | output | 1 | Shared data-ready / data-out pin |
| sleep_o | output | 1 | Sleep state is active |
| cal_busy_o | output | 1 | The wakeup calibration delay is running |

## Verification
Every serial clock edge reaches the logic through two synchroniser stages, so a shifted bit is due on the third master edge after the bench moves `sclk_i`. The bench samples on the falling clock edge after exactly that many rising edges. The sleep boundary is checked on both sides: the bench samples after SLEEP_CYC+1 edges, where sleep must still be off, and after SLEEP_CYC+2, where it must be on. Wakeup is checked the same way around D+2 and D+3 edges after the serial clock falls, with D taken from the bench's own record of whether 25 full pulses were shifted.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_WAKE   = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/sdx_rst_sync.sv
module sdx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdx_sclk_sync.sv
module sdx_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_n;

  always_comb pipe_n = {pipe_q[STAGES-1:0], sclk_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_n;
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/sdx_shift_out.sv
module sdx_shift_out #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              flush_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o,
  output logic              arm_evt_o
);
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_EXTRA = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_DONE  = CNT_W'(DATA_W + 2);

  logic [DATA_W-1:0] data_q, data_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sdo_q, sdo_n;
  logic              upd_en;

  always_comb begin
    data_n    = data_q;
    cnt_n     = cnt_q;
    sdo_n     = sdo_q;
    arm_evt_o = 1'b0;
    if (load_i) begin
      data_n = data_i;
      cnt_n  = '0;
      sdo_n  = 1'b0;
    end else if (flush_i) begin
      cnt_n = CNT_DONE;
      sdo_n = 1'b1;
    end else if (rise_i) begin
      if (cnt_q < CNT_LAST) begin
        sdo_n  = data_q[DATA_W-1];
        data_n = {data_q[DATA_W-2:0], 1'b0};
        cnt_n  = cnt_q + 1'b1;
      end else if (cnt_q == CNT_LAST) begin
        sdo_n = 1'b1;
        cnt_n = CNT_EXTRA;
      end
    end else if (fall_i && cnt_q == CNT_EXTRA) begin
      cnt_n     = CNT_DONE;
      arm_evt_o = 1'b1;
    end
  end

  assign upd_en = load_i | flush_i | rise_i | fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= CNT_DONE;
      sdo_q  <= 1'b1;
    end else if (upd_en) begin
      data_q <= data_n;
      cnt_q  <= cnt_n;
      sdo_q  <= sdo_n;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/sdx_power_ctrl.sv
module sdx_power_ctrl
  import sdx_pkg::*;
#(
  parameter int SLEEP_CYC = 163840,
  parameter int WAKE_CYC  = 165000,
  parameter int CAL_CYC   = 516096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_hi_i,
  input  logic done_i,
  input  logic arm_evt_i,
  output logic load_o,
  output logic flush_o,
  output logic sleep_o,
  output logic cal_busy_o
);
  localparam int HI_W  = $clog2(SLEEP_CYC + 1);
  localparam int TMR_MAX = (CAL_CYC > WAKE_CYC) ? CAL_CYC : WAKE_CYC;
  localparam int TMR_W = $clog2(TMR_MAX + 1);
  localparam logic [HI_W-1:0]  HI_LAST   = HI_W'(SLEEP_CYC - 1);
  localparam logic [TMR_W-1:0] WAKE_LAST = TMR_W'(WAKE_CYC - 1);
  localparam logic [TMR_W-1:0] CAL_LAST  = TMR_W'(CAL_CYC - 1);

  pwr_state_t       st_q, st_n;
  logic [HI_W-1:0]  hi_q, hi_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             armed_q, armed_n;
  logic             seen_q, seen_n;

  always_comb begin
    st_n    = st_q;
    hi_n    = hi_q;
    tmr_n   = tmr_q;
    armed_n = armed_q;
    seen_n  = seen_q;
    load_o  = 1'b0;
    flush_o = 1'b0;
    unique case (st_q)
      PS_ACTIVE: begin
        if (seen_q && sclk_hi_i && hi_q == HI_LAST) begin
          st_n    = PS_SLEEP;
          flush_o = 1'b1;
          seen_n  = 1'b0;
          hi_n    = '0;
        end else begin
          hi_n = (seen_q && sclk_hi_i) ? hi_q + 1'b1 : '0;
          if (arm_evt_i) armed_n = 1'b1;
          if (done_i) begin
            load_o  = 1'b1;
            armed_n = 1'b0;
            seen_n  = 1'b1;
          end
        end
      end
      PS_SLEEP: begin
        if (!sclk_hi_i) begin
          st_n  = PS_WAKE;
          tmr_n = armed_q ? CAL_LAST : WAKE_LAST;
        end
      end
      PS_WAKE: begin
        if (tmr_q == '0) begin
          st_n    = PS_ACTIVE;
          load_o  = 1'b1;
          armed_n = 1'b0;
          seen_n  = 1'b1;
          hi_n    = '0;
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      default: st_n = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_ACTIVE;
      hi_q    <= '0;
      tmr_q   <= '0;
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      hi_q    <= hi_n;
      tmr_q   <= tmr_n;
      armed_q <= armed_n;
      seen_q  <= seen_n;
    end
  end

  assign sleep_o    = (st_q == PS_SLEEP);
  assign cal_busy_o = (st_q == PS_WAKE) && armed_q;
endmodule

// File: rtl/sdx_serial_port.sv
module sdx_serial_port #(
  parameter int DATA_W    = 24,
  parameter int SYNC_ST   = 2,
  parameter int SLEEP_CYC = 163840,
  parameter int WAKE_CYC  = 165000,
  parameter int CAL_CYC   = 516096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sdo_o,
  output logic              sleep_o,
  output logic              cal_busy_o
);
  logic core_rst_n;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic load, flush, arm_evt;

  sdx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  sdx_sclk_sync #(.STAGES(SYNC_ST)) i_sclk_sync (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .sclk_i  (sclk_i),
    .level_o (sclk_lvl),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  sdx_shift_out #(.DATA_W(DATA_W)) i_shift_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load_i    (load),
    .flush_i   (flush),
    .rise_i    (sclk_rise),
    .fall_i    (sclk_fall),
    .data_i    (conv_data_i),
    .sdo_o     (sdo_o),
    .arm_evt_o (arm_evt)
  );

  sdx_power_ctrl #(
    .SLEEP_CYC (SLEEP_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .CAL_CYC   (CAL_CYC)
  ) i_power_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .sclk_hi_i  (sclk_lvl),
    .done_i     (conv_done_i),
    .arm_evt_i  (arm_evt),
    .load_o     (load),
    .flush_o    (flush),
    .sleep_o    (sleep_o),
    .cal_busy_o (cal_busy_o)
  );
endmodule

// File: rtl/sdx_serial_port_chk.sv
module sdx_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_done_i,
  input logic sdo_o,
  input logic sleep_o,
  input logic cal_busy_o
);
  AST_SLEEP_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> sdo_o); // R5

  AST_SLEEP_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && conv_done_i) |=> sdo_o); // R7

  AST_WAKE_NOT_READY_YET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> sdo_o); // R8

  AST_CAL_OUTSIDE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |-> (!sleep_o && sdo_o)); // R9

  AST_READY_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_o |-> (!sleep_o && !cal_busy_o)); // R2
endmodule

bind sdx_serial_port sdx_serial_port_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_done_i (conv_done_i),
  .sdo_o       (sdo_o),
  .sleep_o     (sleep_o),
  .cal_busy_o  (cal_busy_o)
);

// File: tb/test_sdx_serial_port.sv
module test_sdx_serial_port;
  localparam int DW = 24;
  localparam int SLP = 20;
  localparam int WKC = 12;
  localparam int CLC = 30;

  logic clk, rst_n, sclk, done;
  logic [DW-1:0] cdata;
  logic sdo, slp_o, calb;
  logic [DW-1:0] cur;
  int checks, errors;
  bit finished;

  sdx_serial_port #(.DATA_W(DW), .SYNC_ST(2), .SLEEP_CYC(SLP), .WAKE_CYC(WKC),
                    .CAL_CYC(CLC)) i_sdx_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .conv_done_i(done),
    .conv_data_i(cdata), .sdo_o(sdo), .sleep_o(slp_o), .cal_busy_o(calb));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit bit_at(input logic [DW-1:0] d, input int k);
    return d[DW-k];
  endfunction

  task automatic present(input logic [DW-1:0] d);
    @(negedge clk); cdata = d; done = 1'b1;
    @(negedge clk); done = 1'b0;
    cur = d;
    chk(sdo == 1'b0, "R2 ready after load", int'(sdo), 0);
  endtask

  task automatic pulse(input bit exp_sdo, input string req);
    @(negedge clk); sclk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sdo == exp_sdo, req, int'(sdo), int'(exp_sdo));
    repeat ($urandom_range(0, 4)) @(negedge clk);
    chk(slp_o == 1'b0, "R5 short high no sleep", int'(slp_o), 0);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bits(input int k);
    for (int i = 1; i <= k; i++) begin
      if (i <= DW) pulse(bit_at(cur, i), "R3 shifted bit");
      else         pulse(1'b1, "R4 25th rise high");
    end
  endtask

  task automatic sleep_wake(input bit armed, input logic [DW-1:0] nd);
    int d;
    d = armed ? CLC : WKC;
    @(negedge clk); sclk = 1'b1;
    repeat (SLP + 1) @(posedge clk);
    @(negedge clk);
    chk(slp_o == 1'b0, "R5 not asleep before limit", int'(slp_o), 0);
    @(posedge clk); @(negedge clk);
    chk(slp_o == 1'b1, "R5 asleep at limit", int'(slp_o), 1);
    chk(sdo == 1'b1, "R5 pin high asleep", int'(sdo), 1);
    cdata = ~nd; done = 1'b1;
    @(negedge clk); done = 1'b0;
    @(negedge clk);
    chk(sdo == 1'b1, "R7 done ignored asleep", int'(sdo), 1);
    chk(slp_o == 1'b1, "R7 still asleep", int'(slp_o), 1);
    cdata = nd; sclk = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(slp_o == 1'b1, "R8 sleep until sync", int'(slp_o), 1);
    @(posedge clk); @(negedge clk);
    chk(slp_o == 1'b0, "R8 awake", int'(slp_o), 0);
    chk(calb == armed, "R9 cal busy state", int'(calb), int'(armed));
    repeat (d - 1) @(posedge clk); @(negedge clk);
    chk(sdo == 1'b1, "R8 R9 not ready before delay", int'(sdo), 1);
    @(posedge clk); @(negedge clk);
    chk(sdo == 1'b0, "R8 R9 ready at delay", int'(sdo), 0);
    chk(calb == 1'b0, "R10 cal done", int'(calb), 0);
    cur = nd;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] v;
    int k;
    checks = 0; errors = 0; finished = 1'b0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; sclk = 1'b0; done = 1'b0; cdata = '0; cur = '0;
    repeat (4) @(negedge clk);
    chk(sdo == 1'b1 && slp_o == 1'b0 && calb == 1'b0, "R1 in reset",
        {sdo, slp_o, calb}, 3'b100);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo == 1'b1 && slp_o == 1'b0 && calb == 1'b0, "R1 after reset",
        {sdo, slp_o, calb}, 3'b100);
    // R6: long high before any result
    sclk = 1'b1;
    repeat (3 * SLP) @(negedge clk);
    chk(slp_o == 1'b0, "R6 no sleep without result", int'(slp_o), 0);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    // R4 and R10: 25 pulses, extra pulses, then new result drops the arm
    present(24'hA5C3_96);
    read_bits(25);
    pulse(1'b1, "R4 extra rise stays high");
    pulse(1'b1, "R4 extra rise stays high");
    present(24'h3C_0F_F1);
    read_bits(3);
    sleep_wake(1'b0, 24'h80_0001);
    // R9 then R10: calibrated wake, then plain wake afterwards
    read_bits(25);
    sleep_wake(1'b1, 24'h7F_FFFE);
    read_bits(5);
    sleep_wake(1'b0, 24'h12_3456);
    // sleep partway through a readback, right after announce
    read_bits(0);
    sleep_wake(1'b0, 24'hFF_00FF);
    for (int it = 0; it < 24; it++) begin
      k = $urandom_range(0, 25);
      read_bits(k);
      v = DW'($urandom);
      if ($urandom_range(0, 2) != 0) sleep_wake(k == 25, v);
      else present(v);
    end
    read_bits(24);
    finished = 1'b1;
    finish_run();
  end
endmodule